// File: doc/BRIEF.md
# DMA Channel Address/Count Sequencer

This block is the address and count engine behind a group of DMA channels. Software picks a transfer-size mode and a direction for each channel by writing a mode byte. It then loads the channel's page, start address and count, where the count is the transfer length minus one. A requester then strobes the channel once per bus transfer. For each accepted strobe the block produces the full bus address and the byte-lane enables for that transfer. It also moves the channel's address and count to their next values and raises a terminal-count flag on the transfer that finishes the block.

There are four size modes. Two are plain: 8-bit byte-counted, and 16-bit word-counted, in which the address register holds a word address. Two are byte-counted modes for 16-bit and 32-bit paths. In these two modes an unaligned start or end is split into a partial first or last transfer, and the count drops only by the bytes that actually moved. In the word-counted mode the page value is not shifted, so its least significant bit plays no part in the bus address. One shared step calculator serves whichever channel is strobed. The outputs are registered.

Top module: `dma_xfer_seq`

## Requirements
- R1: A mode write selects the channel with data bits [1:0] and stores bits [7:2] in that channel's mode register only. Bits [3:2] set the size: 00 = 8-bit byte-counted, 01 = 16-bit word-counted, 10 = 32-bit byte-counted, 11 = 16-bit byte-counted. Bit 4 set to 1 selects decrement. Bits [7:5] are kept and have no effect.
- R2: After reset no channel is active and out_valid is low. A load writes the page, address and count of the addressed channel and makes that channel active. A load takes priority over a strobe to the same channel in the same cycle.
- R3: In 8-bit mode the bus address is {page, address}, the lane mask is 0001, the address steps by one and the count drops by one.
- R4: In word-counted mode the address register holds the byte address shifted right by one. The bus address is {page[7:1], address, 0}, so page bit 0 is ignored. The lane mask is 0011, the address steps by one word and the count drops by one.
- R5: In 16-bit byte-counted mode with increment, the lanes run from offset address[0] up to the end of the 2-byte block, limited by the bytes remaining. The count drops by the number of lanes set, and the address moves to the next even boundary.
- R6: In 32-bit byte-counted mode with increment, the lanes run from offset address[1:0] up to the end of the 4-byte block, limited by the bytes remaining. The count drops by the number of lanes set, and the address moves to the next multiple of four.
- R7: With decrement in either byte-counted 16/32-bit mode, the lanes end at the current offset and extend toward lane 0, limited by the bytes remaining. The next address is the top byte of the block below.
- R8: out_tc is high on exactly the transfer that moves the final byte (or word). The lanes asserted over the whole transfer sum to count+1 bytes, or twice that in word-counted mode.
- R9: A channel becomes inactive with its terminal-count transfer. A strobe to an inactive channel gives no output and moves nothing.
- R10: The outputs are registered. One cycle after an accepted strobe, out_valid is high with out_ch naming the channel. After a cycle with no accepted strobe, out_valid is low.
- R11: The address register wraps modulo 2^16 with no carry into the page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Mode byte write strobe |
| mode_wdata | input | 8 | Mode byte: [1:0] channel, [3:2] size, [4] decrement, [7:5] spare |
| ld_wr | input | 1 | Load strobe for page/address/count |
| ld_ch | input | 2 | Channel to load |
| ld_page | input | 8 | Page value |
| ld_addr | input | 16 | Start address (word address in word-counted mode) |
| ld_count | input | 16 | Length minus one, in bytes or words |
| xfer_req | input | 1 | Transfer strobe |
| xfer_ch | input | 2 | Channel being strobed |
| out_valid | output | 1 | Registered transfer result valid |
| out_ch | output | 2 | Channel of the result |
| out_addr | output | 24 | Bus byte address |
| out_be | output | 4 | Byte-lane enables |
| out_tc | output | 1 | Terminal count on this transfer |
| ch_active | output | 4 | Per-channel active flags |

## Verification
The assertions check these rules on every cycle: the one-cycle link from an accepted strobe to out_valid, silence after a strobe to an idle channel, the fixed lane masks of the 8-bit and word-counted modes, no upper lanes outside the 32-bit mode, and a channel dropping inactive as it flags terminal count. Some behaviour shows only over whole transfers, and only the bench's sweeps can show it. That covers the split of unaligned starts and ends into partial transfers, the aligned stepping in both directions, terminal count landing on the last byte with the moved-byte total equal to the programmed length, address wrap, and the isolation of one channel's mode from writes to another.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    SZ_B8  = 2'b00,
    SZ_W16 = 2'b01,
    SZ_B32 = 2'b10,
    SZ_B16 = 2'b11
  } size_e;

  // Stored mode field, taken from bits [7:2] of the mode byte
  typedef struct packed {
    logic [2:0] spare;
    logic       down;
    size_e      size;
  } mode_t;

  // Address-register step for each size (word mode steps one word address)
  function automatic logic [2:0] step_unit(size_e s);
    case (s)
      SZ_B32:  step_unit = 3'd4;
      SZ_B16:  step_unit = 3'd2;
      default: step_unit = 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/dma_mode_bank.sv
module dma_mode_bank
  import dma_seq_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr,
  input  logic [7:0]            wdata,
  output mode_t [NCH-1:0]       modes
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic [CH_W-1:0] sel;
  assign sel = wdata[CH_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      modes <= '0;
    end else if (wr) begin
      for (int i = 0; i < NCH; i++) begin
        if (sel == CH_W'(i)) modes[i] <= mode_t'(wdata[7:2]);
      end
    end
  end

endmodule

// File: rtl/dma_chan_state.sv
module dma_chan_state #(
  parameter int PAGE_W = 8,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [PAGE_W-1:0] ld_page,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [CNT_W-1:0]  ld_cnt,
  input  logic              step,
  input  logic [ADDR_W-1:0] nxt_addr,
  input  logic [CNT_W-1:0]  nxt_cnt,
  input  logic              last,
  output logic [PAGE_W-1:0] page_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              active_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q   <= '0;
      addr_q   <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (load) begin
      page_q   <= ld_page;
      addr_q   <= ld_addr;
      cnt_q    <= ld_cnt;
      active_q <= 1'b1;
    end else if (step) begin
      addr_q <= nxt_addr;
      cnt_q  <= nxt_cnt;
      if (last) active_q <= 1'b0;
    end
  end

endmodule

// File: rtl/dma_step_calc.sv
module dma_step_calc
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  size_e             size,
  input  logic              down,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  cnt,
  output logic [3:0]        be,
  output logic [ADDR_W-1:0] nxt_addr,
  output logic [CNT_W-1:0]  nxt_cnt,
  output logic              last
);
  localparam int REM_W = CNT_W + 1;

  logic [2:0]        unit;
  logic [2:0]        off;
  logic [2:0]        avail;
  logic [REM_W-1:0]  rem;
  logic [2:0]        n;
  logic [2:0]        lo;
  logic [2:0]        hi;
  logic [ADDR_W-1:0] amask;

  always_comb begin
    unit = step_unit(size);
    case (size)
      SZ_B32:  off = {1'b0, addr[1:0]};
      SZ_B16:  off = {2'b00, addr[0]};
      default: off = 3'd0;
    endcase

    // Units this transfer can cover before leaving the aligned block
    avail = down ? (off + 3'd1) : (unit - off);
    rem   = {1'b0, cnt} + REM_W'(1);

    if (rem <= REM_W'(avail)) begin
      n    = rem[2:0];
      last = 1'b1;
    end else begin
      n    = avail;
      last = 1'b0;
    end

    if (down) begin
      hi = off;
      lo = off - n + 3'd1;
    end else begin
      lo = off;
      hi = off + n - 3'd1;
    end

    for (int i = 0; i < 4; i++) begin
      be[i] = (3'(i) >= lo) && (3'(i) <= hi);
    end
    if (size == SZ_W16) be = 4'b0011;

    amask    = ADDR_W'(unit) - ADDR_W'(1);
    nxt_addr = down ? ((addr | amask) - ADDR_W'(unit))
                    : ((addr & ~amask) + ADDR_W'(unit));
    nxt_cnt  = cnt - CNT_W'(n);
  end

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_seq_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int PAGE_W = 8,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int BUS_W = PAGE_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_wr,
  input  logic [7:0]        mode_wdata,
  input  logic              ld_wr,
  input  logic [CH_W-1:0]   ld_ch,
  input  logic [PAGE_W-1:0] ld_page,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [CNT_W-1:0]  ld_count,
  input  logic              xfer_req,
  input  logic [CH_W-1:0]   xfer_ch,
  output logic              out_valid,
  output logic [CH_W-1:0]   out_ch,
  output logic [BUS_W-1:0]  out_addr,
  output logic [3:0]        out_be,
  output logic              out_tc,
  output logic [NCH-1:0]    ch_active
);

  mode_t [NCH-1:0]   modes;
  logic [PAGE_W-1:0] page_a [NCH];
  logic [ADDR_W-1:0] addr_a [NCH];
  logic [CNT_W-1:0]  cnt_a  [NCH];

  logic              take;
  mode_t             sel_mode;
  logic [PAGE_W-1:0] sel_page;
  logic [ADDR_W-1:0] sel_addr;
  logic [CNT_W-1:0]  sel_cnt;
  logic [3:0]        calc_be;
  logic [ADDR_W-1:0] calc_addr;
  logic [CNT_W-1:0]  calc_cnt;
  logic              calc_last;
  logic [BUS_W-1:0]  bus_addr;

  dma_mode_bank #(.NCH(NCH)) u_modes (
    .clk   (clk),
    .rst   (rst),
    .wr    (mode_wr),
    .wdata (mode_wdata),
    .modes (modes)
  );

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      logic ld_here;
      logic step_here;
      assign ld_here   = ld_wr && (ld_ch == CH_W'(g));
      assign step_here = take && (xfer_ch == CH_W'(g));

      dma_chan_state #(
        .PAGE_W(PAGE_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
      ) u_state (
        .clk      (clk),
        .rst      (rst),
        .load     (ld_here),
        .ld_page  (ld_page),
        .ld_addr  (ld_addr),
        .ld_cnt   (ld_count),
        .step     (step_here),
        .nxt_addr (calc_addr),
        .nxt_cnt  (calc_cnt),
        .last     (calc_last),
        .page_q   (page_a[g]),
        .addr_q   (addr_a[g]),
        .cnt_q    (cnt_a[g]),
        .active_q (ch_active[g])
      );
    end
  endgenerate

  // Strobe accepted only for an active channel not being reloaded now
  assign take = xfer_req && ch_active[xfer_ch] && !(ld_wr && (ld_ch == xfer_ch));

  assign sel_mode = modes[xfer_ch];
  assign sel_page = page_a[xfer_ch];
  assign sel_addr = addr_a[xfer_ch];
  assign sel_cnt  = cnt_a[xfer_ch];

  dma_step_calc #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_calc (
    .size     (sel_mode.size),
    .down     (sel_mode.down),
    .addr     (sel_addr),
    .cnt      (sel_cnt),
    .be       (calc_be),
    .nxt_addr (calc_addr),
    .nxt_cnt  (calc_cnt),
    .last     (calc_last)
  );

  // Word mode: shifted address, page LSB dropped
  always_comb begin
    if (sel_mode.size == SZ_W16) bus_addr = {sel_page[PAGE_W-1:1], sel_addr, 1'b0};
    else                         bus_addr = {sel_page, sel_addr};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_ch    <= '0;
      out_addr  <= '0;
      out_be    <= '0;
      out_tc    <= 1'b0;
    end else begin
      out_valid <= take;
      if (take) begin
        out_ch   <= xfer_ch;
        out_addr <= bus_addr;
        out_be   <= calc_be;
        out_tc   <= calc_last;
      end else begin
        out_tc   <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dma_xfer_seq_chk.sv
module dma_xfer_seq_chk
  import dma_seq_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int CH_W  = 2,
  parameter int BUS_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             xfer_req,
  input logic [CH_W-1:0]  xfer_ch,
  input logic             ld_wr,
  input logic [CH_W-1:0]  ld_ch,
  input logic             out_valid,
  input logic [CH_W-1:0]  out_ch,
  input logic [BUS_W-1:0] out_addr,
  input logic [3:0]       out_be,
  input logic             out_tc,
  input logic [NCH-1:0]   ch_active,
  input mode_t [NCH-1:0]  modes
);

  logic accepted;
  assign accepted = xfer_req && ch_active[xfer_ch] && !(ld_wr && (ld_ch == xfer_ch));

  // R10: accepted strobe shows up one cycle later on the named channel
  assert_strobe_to_valid_R10: assert property (@(posedge clk) disable iff (rst)
    accepted |=> (out_valid && out_ch == $past(xfer_ch)));

  // R9: strobe to an idle channel produces nothing
  assert_idle_silent_R9: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && !ch_active[xfer_ch]) |=> !out_valid);

  // R9: terminal count leaves the channel inactive
  assert_tc_stops_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_tc) |-> !ch_active[out_ch]);

  // R8: terminal count only on a valid transfer
  assert_tc_valid_R8: assert property (@(posedge clk) disable iff (rst)
    out_tc |-> out_valid);

  // R3: 8-bit mode drives lane 0 only
  assert_byte_lane_R3: assert property (@(posedge clk) disable iff (rst)
    (accepted && modes[xfer_ch].size == SZ_B8) |=> (out_be == 4'b0001));

  // R4: word mode drives two lanes at an even bus address
  assert_word_lanes_R4: assert property (@(posedge clk) disable iff (rst)
    (accepted && modes[xfer_ch].size == SZ_W16) |=> (out_be == 4'b0011 && !out_addr[0]));

  // R5: 16-bit byte-counted mode never touches the upper lanes
  assert_half_lanes_R5: assert property (@(posedge clk) disable iff (rst)
    (accepted && modes[xfer_ch].size == SZ_B16) |=> (out_be[3:2] == 2'b00 && out_be != 4'b0000));

  // R6: every 32-bit transfer moves at least one byte
  assert_dword_lanes_R6: assert property (@(posedge clk) disable iff (rst)
    (accepted && modes[xfer_ch].size == SZ_B32) |=> ($countones(out_be) >= 1));

endmodule

bind dma_xfer_seq dma_xfer_seq_chk #(
  .NCH(NCH), .CH_W(CH_W), .BUS_W(BUS_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .xfer_req  (xfer_req),
  .xfer_ch   (xfer_ch),
  .ld_wr     (ld_wr),
  .ld_ch     (ld_ch),
  .out_valid (out_valid),
  .out_ch    (out_ch),
  .out_addr  (out_addr),
  .out_be    (out_be),
  .out_tc    (out_tc),
  .ch_active (ch_active),
  .modes     (modes)
);

// File: tb/dma_xfer_seq_tb.sv
module dma_xfer_seq_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_wr = 1'b0;
  logic [7:0]  mode_wdata = '0;
  logic        ld_wr = 1'b0;
  logic [1:0]  ld_ch = '0;
  logic [7:0]  ld_page = '0;
  logic [15:0] ld_addr = '0;
  logic [15:0] ld_count = '0;
  logic        xfer_req = 1'b0;
  logic [1:0]  xfer_ch = '0;
  logic        out_valid;
  logic [1:0]  out_ch;
  logic [23:0] out_addr;
  logic [3:0]  out_be;
  logic        out_tc;
  logic [3:0]  ch_active;

  int checks = 0;
  int bad    = 0;
  bit ended  = 0;

  localparam logic [7:0] PG = 8'h5B;

  always #5 clk = ~clk;

  dma_xfer_seq u_dut (
    .clk(clk), .rst(rst),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .ld_wr(ld_wr), .ld_ch(ld_ch), .ld_page(ld_page), .ld_addr(ld_addr), .ld_count(ld_count),
    .xfer_req(xfer_req), .xfer_ch(xfer_ch),
    .out_valid(out_valid), .out_ch(out_ch), .out_addr(out_addr), .out_be(out_be),
    .out_tc(out_tc), .ch_active(ch_active)
  );

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  task automatic write_mode(int ch, int sz, bit dn, int spare);
    mode_wr    = 1'b1;
    mode_wdata = {spare[2:0], dn, sz[1:0], ch[1:0]};
    @(negedge clk);
    mode_wr    = 1'b0;
  endtask

  task automatic load(int ch, logic [7:0] pg, logic [15:0] a, logic [15:0] c);
    ld_wr = 1'b1; ld_ch = ch[1:0]; ld_page = pg; ld_addr = a; ld_count = c;
    @(negedge clk);
    ld_wr = 1'b0;
  endtask

  // One strobe; outputs are sampled at the following negedge
  task automatic strobe(int ch);
    xfer_req = 1'b1; xfer_ch = ch[1:0];
    @(negedge clk);
    xfer_req = 1'b0;
  endtask

  task automatic run_case(int sz, bit dn, int start, int len, int ch, int spare);
    int w, p, left, n, lo, nx, tcs, moved, seq_bad, blk;
    bit tc_last;
    logic [3:0]  ebe;
    logic [23:0] eaddr;
    longint fa, fe;
    string tag;
    w = (sz == 2) ? 4 : (sz == 3) ? 2 : 1;
    write_mode(ch, sz, dn, spare);
    load(ch, PG, 16'(start), 16'(len - 1));
    p = start; left = len; nx = 0; tcs = 0; moved = 0; seq_bad = 0; tc_last = 1;
    fa = 0; fe = 0;
    while (left > 0 && nx < 16) begin
      if (sz == 1) begin
        n = 1; ebe = 4'b0011;
        eaddr = ({16'h0, PG & 8'hFE} << 16) | (24'(p[15:0]) << 1);
        p = dn ? p - 1 : p + 1;
      end else begin
        eaddr = {PG, p[15:0]};
        if (!dn) begin
          blk = p | (w - 1);
          n = (blk - p + 1 < left) ? blk - p + 1 : left;
          lo = p % w;
          p = blk + 1;
        end else begin
          blk = p & ~(w - 1);
          n = (p - blk + 1 < left) ? p - blk + 1 : left;
          lo = (p % w) - n + 1;
          p = blk - 1;
        end
        ebe = 4'(((1 << n) - 1) << lo);
      end
      strobe(ch);
      if (!out_valid || out_ch != ch[1:0] || out_addr != eaddr || out_be != ebe) begin
        if (seq_bad == 0) begin
          fa = {out_valid, out_be, out_addr};
          fe = {1'b1, ebe, eaddr};
        end
        seq_bad++;
      end
      moved += $countones(out_be);
      left -= n;
      if (out_tc) begin
        tcs++;
        if (left != 0) tc_last = 0;
      end
      nx++;
    end
    case (sz)
      0: tag = "R3";
      1: tag = "R4";
      2: tag = "R6";
      default: tag = "R5";
    endcase
    if (dn && (sz == 2 || sz == 3)) tag = {tag, " R7"};
    check(seq_bad == 0, tag, $sformatf("seq sz=%0d dn=%0d start=%0h len=%0d", sz, dn, start, len), fa, fe);
    check(tcs == 1 && tc_last, "R8", "tc on final transfer", tcs, 1);
    check(moved == ((sz == 1) ? 2 * len : len), "R8", "bytes moved", moved, (sz == 1) ? 2 * len : len);
    check(ch_active[ch] == 1'b0, "R9", "inactive after tc", ch_active[ch], 0);
    strobe(ch);
    check(out_valid == 1'b0, "R9", "strobe after tc ignored", out_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    int lens [6] = '{1, 2, 3, 4, 5, 9};
    int idx;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R2", "reset valid", out_valid, 0);
    check(ch_active == 4'b0, "R2", "reset active", ch_active, 0);
    strobe(2);
    check(out_valid == 1'b0, "R9", "strobe before load", out_valid, 0);
    load(2, PG, 16'h0040, 16'd3);
    check(ch_active[2] == 1'b1, "R2", "load activates", ch_active, 4'b0100);

    // Load beats strobe on the same channel in the same cycle
    ld_wr = 1'b1; ld_ch = 2'd2; ld_page = PG; ld_addr = 16'h0080; ld_count = 16'd1;
    xfer_req = 1'b1; xfer_ch = 2'd2;
    @(negedge clk);
    ld_wr = 1'b0; xfer_req = 1'b0;
    check(out_valid == 1'b0, "R2", "load wins over strobe", out_valid, 0);
    write_mode(2, 0, 0, 0);
    strobe(2);
    check(out_addr == {PG, 16'h0080}, "R2", "reloaded address used", out_addr, {PG, 16'h0080});

    // Sweep every mode, direction, offset and length
    idx = 0;
    for (int sz = 0; sz < 4; sz++) begin
      for (int dn = 0; dn < 2; dn++) begin
        for (int off = 0; off < 4; off++) begin
          for (int li = 0; li < 6; li++) begin
            run_case(sz, dn[0], ((sz == 1) ? 16'h0918 : 16'h1230) + off, lens[li], idx % 4, idx % 8);
            idx++;
          end
        end
      end
    end

    // R1: a mode write to one channel leaves another untouched
    write_mode(1, 0, 0, 0);
    load(1, PG, 16'h1231, 16'd3);
    write_mode(2, 2, 1, 7);
    strobe(1);
    check(out_be == 4'b0001 && out_addr == {PG, 16'h1232 - 16'd1}, "R1", "other channel mode kept",
          {out_be, out_addr}, {4'b0001, PG, 16'h1231});

    // R11: 8-bit address wrap keeps the page
    write_mode(0, 0, 0, 0);
    load(0, PG, 16'hFFFF, 16'd1);
    strobe(0);
    check(out_addr == {PG, 16'hFFFF}, "R11", "before wrap", out_addr, {PG, 16'hFFFF});
    strobe(0);
    check(out_addr == {PG, 16'h0000} && out_tc, "R11", "after wrap", out_addr, {PG, 16'h0000});
    @(negedge clk);
    check(out_valid == 1'b0, "R10", "valid drops without strobe", out_valid, 0);

    finish_run();
  end

endmodule